// File: doc/BRIEF.md
# Parallel Byte-Bridge Loopback Master

This block sits on the FPGA side of a synchronous parallel FIFO bridge: an external chip that holds a receive queue and a transmit queue and shares one 8-bit bidirectional data bus with the FPGA. The block runs from the clock that the bridge itself supplies. It drains bytes from the bridge's receive queue into a local buffer. It then writes them back into the bridge's transmit queue in arrival order, so that whatever the host sends comes back unchanged.

Reads and writes share the bus, so the block switches between a receive phase and a transmit phase. Before it pulses the read strobe, it holds the bridge's output enable low for a full cycle so the bus can turn around. It leaves the bus undriven for one cycle after it releases the output enable. Every rising edge at which a flag and its strobe are both low moves one byte. The block also stops a burst cleanly when the bridge withdraws its flag, and when its own buffer fills.

The bus is split into separate input, output and drive-enable signals; the tristate pad sits outside this block.

Top module: `fifo_bridge_loopback`

## Requirements
- R1: While reset is asserted, the output-enable, read-strobe and write-strobe pins are all high (inactive) and the data bus is not driven.
- R2: The send-immediate/wake pin is held high at all times.
- R3: The read strobe only goes low in a cycle where the output enable was already low in the previous cycle.
- R4: On each rising edge where the receive-available flag and the read strobe are both low, the bus byte is stored. No byte is stored on an edge where the flag is high, and no read starts while the flag is high.
- R5: If the receive-available flag is high at an edge during a read burst, the read strobe is high in the next cycle while output enable is still low. Output enable is high one cycle after that.
- R6: Stored bytes are written to the bridge in arrival order, one on each rising edge where the transmit-space flag and the write strobe are both low, with no byte dropped or repeated.
- R7: If the transmit-space flag is high at an edge during a write burst, that byte is not consumed. The write strobe is high in the next cycle, and the same byte is offered again when writing resumes.
- R8: The block drives the bus only while the write strobe is low and output enable is high. It never drives the bus in the cycle just after output enable is released.
- R9: The local buffer holds DEPTH bytes (default 16). Once it is full, the read strobe rises and no further byte is read until space is freed by transmission.
- R10: When the buffer is idle and both a receive and a transmit are possible, a receive burst starts first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Interface clock supplied by the bridge |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| rx_empty_ni | input | 1 | Low when the bridge's receive queue holds data |
| tx_full_ni | input | 1 | Low when the bridge's transmit queue accepts data |
| oe_no | output | 1 | Active-low request for the bridge to drive the bus |
| rd_no | output | 1 | Active-low read strobe |
| wr_no | output | 1 | Active-low write strobe |
| wake_no | output | 1 | Send-immediate/wake pin, held high |
| bus_i | input | 8 | Data bus value from the pad |
| bus_o | output | 8 | Data bus value to the pad |
| bus_oe_o | output | 1 | High when the FPGA drives the bus pad |

## Verification
A corrupted pointer or count in the buffer shows at the ports as a returned byte stream that differs from the sent stream. It appears on the first write burst after the fault: a wrong byte, a repeated byte or a missing byte. A stuck or mis-sequenced control state shows within one cycle as a read strobe without the output-enable lead, a bus drive that overlaps output enable, or a strobe that stays low after its flag has risen. The directed scenarios place flag withdrawals at known cycles, so each such fault is seen at a fixed edge.

// File: rtl/fbl_pkg.sv
package fbl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_RX_TURN  = 3'd1,
    ST_RX_BURST = 3'd2,
    ST_RX_STOP  = 3'd3,
    ST_TX_BURST = 3'd4
  } fbl_state_e;
endpackage

// File: rtl/fbl_buffer.sv
module fbl_buffer #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] din_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] head_o,
  output logic [CNT_W-1:0] count_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] count_q, count_d;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    count_d  = count_q;
    if (push_i) begin
      wr_ptr_d = (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
    end
    if (pop_i) begin
      rd_ptr_d = (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
    end
    if (push_i && !pop_i) begin
      count_d = count_q + 1'b1;
    end else if (pop_i && !push_i) begin
      count_d = count_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (push_i || pop_i) begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) begin
      mem_q[wr_ptr_q] <= din_i;
    end
  end

  assign head_o  = mem_q[rd_ptr_q];
  assign count_o = count_q;

  // R9
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (count_q < CNT_W'(DEPTH)));
  // R6
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (count_q != '0));
endmodule

// File: rtl/fbl_seq.sv
module fbl_seq
  import fbl_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rxf_ni,
  input  logic             txe_ni,
  input  logic [CNT_W-1:0] count_i,
  output logic             push_o,
  output logic             pop_o,
  output logic             oe_no,
  output logic             rd_no,
  output logic             wr_no,
  output logic             drive_o
);
  fbl_state_e state_q, state_d;
  logic has_room, has_data, room_after_push;

  assign has_room        = (count_i < CNT_W'(DEPTH));
  assign has_data        = (count_i != '0);
  assign room_after_push = (count_i < CNT_W'(DEPTH - 1));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (!rxf_ni && has_room)       state_d = ST_RX_TURN;
        else if (!txe_ni && has_data)  state_d = ST_TX_BURST;
      end
      ST_RX_TURN:  state_d = rxf_ni ? ST_RX_STOP : ST_RX_BURST;
      ST_RX_BURST: begin
        if (rxf_ni || !room_after_push) state_d = ST_RX_STOP;
      end
      ST_RX_STOP:  state_d = ST_IDLE;
      ST_TX_BURST: begin
        if (txe_ni)                      state_d = ST_IDLE;
        else if (count_i == CNT_W'(1))   state_d = ST_IDLE;
      end
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign oe_no   = !(state_q inside {ST_RX_TURN, ST_RX_BURST, ST_RX_STOP});
  assign rd_no   = (state_q != ST_RX_BURST);
  assign wr_no   = (state_q != ST_TX_BURST);
  assign drive_o = (state_q == ST_TX_BURST);
  assign push_o  = !rd_no && !rxf_ni;
  assign pop_o   = !wr_no && !txe_ni;

  // R3
  oe_lead_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_no && $past(rd_no)) |-> $past(!oe_no));
  // R8
  bus_turn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_o |-> (oe_no && $past(oe_no) && !wr_no));
  // R5
  rx_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_no && rxf_ni) |=> (rd_no && !oe_no));
  // R7
  tx_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_no && txe_ni) |=> wr_no);
  // R4
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_no && !wr_no));
endmodule

// File: rtl/fifo_bridge_loopback.sv
module fifo_bridge_loopback #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_empty_ni,
  input  logic              tx_full_ni,
  output logic              oe_no,
  output logic              rd_no,
  output logic              wr_no,
  output logic              wake_no,
  input  logic [DATA_W-1:0] bus_i,
  output logic [DATA_W-1:0] bus_o,
  output logic              bus_oe_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             push, pop;
  logic [CNT_W-1:0] count;

  fbl_buffer #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .din_i   (bus_i),
    .pop_i   (pop),
    .head_o  (bus_o),
    .count_o (count)
  );

  fbl_seq #(.DEPTH(DEPTH)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rxf_ni  (rx_empty_ni),
    .txe_ni  (tx_full_ni),
    .count_i (count),
    .push_o  (push),
    .pop_o   (pop),
    .oe_no   (oe_no),
    .rd_no   (rd_no),
    .wr_no   (wr_no),
    .drive_o (bus_oe_o)
  );

  assign wake_no = 1'b1;
endmodule

// File: tb/fifo_bridge_loopback_test.sv
`timescale 1ns/1ps
module fifo_bridge_loopback_test;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_block = 1'b1;
  logic tx_block = 1'b1;
  logic rx_empty_n, tx_full_n;
  logic oe_n, rd_n, wr_n, wake_n, bus_oe;
  logic [7:0] bus_in, bus_out;

  logic [7:0] rx_mem [256];
  logic [7:0] tx_log [256];
  int rx_wr = 0, rx_rd = 0, tx_cnt = 0;
  int n_checks = 0, n_fail = 0, cyc = 0;
  int viol_lead = 0, viol_drive = 0, viol_wake = 0;
  logic prev_oe = 1'b1, prev_rd = 1'b1;

  always #2.5 clk = ~clk;

  assign rx_empty_n = rx_block || (rx_rd == rx_wr);
  assign tx_full_n  = tx_block;
  assign bus_in     = oe_n ? 8'h00 : rx_mem[rx_rd[7:0]];

  fifo_bridge_loopback #(.DATA_W(8), .DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .rx_empty_ni(rx_empty_n), .tx_full_ni(tx_full_n),
    .oe_no(oe_n), .rd_no(rd_n), .wr_no(wr_n), .wake_no(wake_n),
    .bus_i(bus_in), .bus_o(bus_out), .bus_oe_o(bus_oe)
  );

  // bridge model: consumes and logs bytes on qualifying edges
  always @(posedge clk) begin
    if (rst_n && !rx_empty_n && !rd_n) rx_rd <= rx_rd + 1;
    if (rst_n && !tx_full_n && !wr_n) begin
      tx_log[tx_cnt[7:0]] <= bus_out;
      tx_cnt <= tx_cnt + 1;
    end
  end

  // pin-level monitors
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (bus_oe && (!oe_n || !prev_oe || wr_n)) viol_drive <= viol_drive + 1;
      if (!rd_n && prev_rd && prev_oe) viol_lead <= viol_lead + 1;
      if (!wake_n) viol_wake <= viol_wake + 1;
    end
    prev_oe <= oe_n;
    prev_rd <= rd_n;
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  always @(negedge clk) begin
    if (cyc > 100000) begin
      n_checks = n_checks + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual cycles %0d expected below 100000", cyc);
      finish_run();
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load(input int n);
    for (int i = 0; i < n; i++) begin
      rx_mem[rx_wr[7:0]] = 8'((rx_wr * 37 + 11) ^ (rx_wr >> 2));
      rx_wr = rx_wr + 1;
    end
  endtask

  task automatic wait_tx(input int n);
    for (int k = 0; k < 4000 && tx_cnt < n; k++) @(negedge clk);
  endtask

  task automatic check_order(input int first, input int last, input string req);
    int bad = 0;
    for (int i = first; i < last; i++) if (tx_log[i[7:0]] !== rx_mem[i[7:0]]) bad++;
    check(bad == 0 && tx_cnt == last, req, tx_cnt - bad, last);
  endtask

  task automatic t_reset();
    @(negedge clk);
    // R1
    check(oe_n && rd_n && wr_n && !bus_oe, "R1", {oe_n, rd_n, wr_n, bus_oe}, 4'b1110);
    // R2
    check(wake_n == 1'b1, "R2", wake_n, 1);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_simple();
    int base = rx_wr;
    load(5);
    tx_block = 1'b0;
    rx_block = 1'b0;
    wait_tx(base + 5);
    repeat (10) @(negedge clk);
    // R6: simple echo in order
    check_order(base, base + 5, "R6");
    tx_block = 1'b1;
  endtask

  task automatic t_rx_gap();
    int base = rx_wr;
    int held;
    load(10);
    rx_block = 1'b0;
    for (int k = 0; k < 50 && rd_n; k++) @(negedge clk);
    repeat (2) @(negedge clk);
    rx_block = 1'b1;
    held = rx_rd;
    @(negedge clk);
    // R5: read strobe up, output enable still low
    check(rd_n && !oe_n, "R5", {rd_n, oe_n}, 2'b10);
    // R4: nothing taken while flag high
    check(rx_rd == held, "R4", rx_rd, held);
    @(negedge clk);
    // R5: output enable released a cycle later
    check(oe_n == 1'b1, "R5", oe_n, 1);
    repeat (4) @(negedge clk);
    // R4: no read attempt while flag high
    check(rd_n && rx_rd == held, "R4", rx_rd, held);
    rx_block = 1'b0;
    for (int k = 0; k < 200 && rx_rd != rx_wr; k++) @(negedge clk);
    repeat (4) @(negedge clk);
    tx_block = 1'b0;
    wait_tx(base + 10);
    repeat (10) @(negedge clk);
    // R4: every byte taken exactly once
    check_order(base, base + 10, "R4");
    tx_block = 1'b1;
  endtask

  task automatic t_full();
    int base = rx_wr;
    load(20);
    rx_block = 1'b0;
    repeat (80) @(negedge clk);
    // R9: buffer fills and reading stops
    check(rx_rd - base == DEPTH, "R9", rx_rd - base, DEPTH);
    check(rd_n == 1'b1, "R9", rd_n, 1);
    tx_block = 1'b0;
    wait_tx(base + 20);
    repeat (10) @(negedge clk);
    check_order(base, base + 20, "R9");
    tx_block = 1'b1;
  endtask

  task automatic t_tx_stall();
    int base = rx_wr;
    load(8);
    rx_block = 1'b0;
    for (int k = 0; k < 200 && rx_rd != rx_wr; k++) @(negedge clk);
    repeat (4) @(negedge clk);
    tx_block = 1'b0;
    for (int k = 0; k < 200 && tx_cnt < base + 3; k++) @(negedge clk);
    tx_block = 1'b1;
    @(negedge clk);
    // R7: write strobe released, byte not consumed
    check(wr_n && !bus_oe, "R7", {wr_n, bus_oe}, 2'b10);
    repeat (5) @(negedge clk);
    check(tx_cnt == base + 3, "R7", tx_cnt, base + 3);
    tx_block = 1'b0;
    wait_tx(base + 8);
    repeat (10) @(negedge clk);
    // R7: held byte offered again, none lost
    check_order(base, base + 8, "R7");
    tx_block = 1'b1;
  endtask

  task automatic t_priority();
    int base = rx_wr;
    load(2);
    rx_block = 1'b0;
    for (int k = 0; k < 100 && rx_rd != rx_wr; k++) @(negedge clk);
    repeat (4) @(negedge clk);
    rx_block = 1'b1;
    load(3);
    @(negedge clk);
    tx_block = 1'b0;
    rx_block = 1'b0;
    @(negedge clk);
    // R10: receive phase wins when both possible
    check(!oe_n && wr_n, "R10", {oe_n, wr_n}, 2'b01);
    wait_tx(base + 5);
    repeat (10) @(negedge clk);
    check_order(base, base + 5, "R10");
    tx_block = 1'b1;
  endtask

  task automatic t_stream();
    int base = rx_wr;
    load(40);
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      tx_block = (k % 7 == 3) || (k % 11 == 5);
      rx_block = (k % 5 == 2);
    end
    tx_block = 1'b0;
    rx_block = 1'b0;
    wait_tx(base + 40);
    repeat (30) @(negedge clk);
    // R6: mixed flag activity, order kept
    check_order(base, base + 40, "R6");
  endtask

  initial begin
    t_reset();
    t_simple();
    t_rx_gap();
    t_full();
    t_tx_stall();
    t_priority();
    t_stream();
    // R3
    check(viol_lead == 0, "R3", viol_lead, 0);
    // R8
    check(viol_drive == 0, "R8", viol_drive, 0);
    // R2
    check(viol_wake == 0, "R2", viol_wake, 0);
    finish_run();
  end
endmodule